// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Set and Clear

This block is a 32-channel general-purpose I/O port that sits on a simple word-wide register bus. It keeps an output data word and a per-channel direction word, and it drives both straight to the pad side as `pin_out` and `pin_oe`. The input pins pass through a two-stage synchronizer. Software reads the synchronized levels as a data-in word.

Software can change output bits in three ways. It can write the whole data-out word. It can write a word to the set alias, which raises only the bits that are 1 in that word. It can write a word to the clear alias, which lowers only the bits that are 1 in that word. Because of the two aliases, several tasks can each drive their own pins without a read-modify-write. A fixed identification word and a fixed hardware configuration word are also readable. The bus has no handshake. A write or read strobe completes in a single cycle, and read data is registered, so it appears one clock after the read strobe.

Top module: `gpio_port`

## Requirements
- R1: While `rst` is high at a clock edge, data-out, direction and the read-data register become all zero, so every channel starts as an input with `pin_oe` = 0 and `pin_out` = 0.
- R2: A write to offset 0x24 replaces the data-out word. `pin_out` shows the new word after that clock edge, and a read of 0x24 returns it.
- R3: A write to offset 0x2C forces to 0 each data-out bit whose written bit is 1. All other bits keep their value.
- R4: A write to offset 0x30 forces to 1 each data-out bit whose written bit is 1. All other bits keep their value.
- R5: A write to offset 0x28 replaces the direction word. Bit n = 1 makes channel n an output (`pin_oe[n]` = 1), bit n = 0 makes it an input. A read of 0x28 returns the word.
- R6: A read of offset 0x20 returns the input pin levels. Any level held stable for at least two clock edges before the read strobe's edge is reported.
- R7: A read of offset 0x00 returns the parameter `ID_WORD`. A read of offset 0x10 returns the parameter `CFG_WORD`.
- R8: A write to a read-only offset (0x00, 0x10, 0x20) or to an unmapped offset changes neither data-out nor direction. A read of an unmapped offset, or of the write-only offsets 0x2C and 0x30, returns 0.
- R9: `bus_rdata` is loaded at the clock edge where `bus_rd` is high and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous input pin levels |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Per-channel output enable |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle and that the address and write data are stable and known whenever a strobe is high. The stimulus drives each operation as one strobe cycle from the falling clock edge and never raises both strobes together. Input pins change only in their own step, which is followed by idle cycles, so every data-in read meets the two-edge settling rule.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_IDENT = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_HWCFG = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_DRIVE = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_OEN   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_LOWER = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_RAISE = 8'h30;

    typedef struct packed {
        logic ident;
        logic hwcfg;
        logic level;
        logic drive;
        logic oen;
        logic lower;
        logic raise;
    } reg_hit_t;

    typedef struct packed {
        logic [DATA_W-1:0] drive;
        logic [DATA_W-1:0] oen;
    } port_state_t;

    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_hit_t h;
        h.ident = (a == OFS_IDENT);
        h.hwcfg = (a == OFS_HWCFG);
        h.level = (a == OFS_LEVEL);
        h.drive = (a == OFS_DRIVE);
        h.oen   = (a == OFS_OEN);
        h.lower = (a == OFS_LOWER);
        h.raise = (a == OFS_RAISE);
        return h;
    endfunction

    function automatic logic [DATA_W-1:0] merge_bits(
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] mask,
        input logic              to_one
    );
        return to_one ? (cur | mask) : (cur & ~mask);
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_hit_t          hit,
    input  logic [DATA_W-1:0] wdata,
    output port_state_t       state
);
    port_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (hit.drive) state_d.drive = wdata;
            if (hit.lower) state_d.drive = merge_bits(state_q.drive, wdata, 1'b0);
            if (hit.raise) state_d.drive = merge_bits(state_q.drive, wdata, 1'b1);
            if (hit.oen)   state_d.oen   = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign state = state_q;

    AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (state_q == '0)); // R1

    AST_LOWER_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit.lower) |=>
            ((state_q.drive & $past(wdata)) == '0) &&
            ((state_q.drive & ~$past(wdata)) == ($past(state_q.drive) & ~$past(wdata)))); // R3

    AST_RAISE_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit.raise) |=>
            ((state_q.drive & $past(wdata)) == $past(wdata)) &&
            ((state_q.drive & ~$past(wdata)) == ($past(state_q.drive) & ~$past(wdata)))); // R4

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (hit.drive || hit.lower || hit.raise || hit.oen)) |=>
            $stable(state_q)); // R8

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit.oen) |=> (state_q.oen == $past(wdata))); // R5
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_WORD  = 32'h0000_0000,
    parameter logic [DATA_W-1:0] CFG_WORD = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  reg_hit_t          hit,
    input  port_state_t       state,
    input  logic [DATA_W-1:0] level,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] sel_word;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        sel_word = '0;
        if (hit.ident) sel_word = ID_WORD;
        if (hit.hwcfg) sel_word = CFG_WORD;
        if (hit.level) sel_word = level;
        if (hit.drive) sel_word = state.drive;
        if (hit.oen)   sel_word = state.oen;
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= sel_word;
    end

    assign rdata = rdata_q;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata_q)); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(hit.ident || hit.hwcfg || hit.level || hit.drive || hit.oen)) |=>
            (rdata_q == '0)); // R8

    AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && hit.ident) |=> (rdata_q == ID_WORD)); // R7
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter logic [31:0] ID_WORD   = 32'h0A51_0100,
    parameter logic [31:0] CFG_WORD  = 32'h0000_0020,
    parameter int          SYNC_LEN  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] pin_in,
    output logic [31:0] pin_out,
    output logic [31:0] pin_oe
);
    reg_hit_t          hit;
    port_state_t       state;
    logic [DATA_W-1:0] level;

    assign hit = decode_addr(bus_addr);

    gpio_in_sync #(.W(DATA_W), .STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (level)
    );

    gpio_out_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .hit   (hit),
        .wdata (bus_wdata),
        .state (state)
    );

    gpio_read_mux #(.ID_WORD(ID_WORD), .CFG_WORD(CFG_WORD)) u_rmux (
        .clk   (clk),
        .rst   (rst),
        .rd_en (bus_rd),
        .hit   (hit),
        .state (state),
        .level (level),
        .rdata (bus_rdata)
    );

    assign pin_out = state.drive;
    assign pin_oe  = state.oen;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd)); // R9

    AST_DRIVE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit.drive) |=> (pin_out == $past(bus_wdata))); // R2
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    localparam logic [31:0] ID_W  = 32'h0A51_0100;
    localparam logic [31:0] CFG_W = 32'h0000_0020;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_dout = '0;
    logic [31:0] m_dir  = '0;

    always #5 clk = ~clk;

    gpio_port #(.ID_WORD(ID_W), .CFG_WORD(CFG_W)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic is_mapped(input logic [7:0] a);
        return a == 8'h00 || a == 8'h10 || a == 8'h20 || a == 8'h24 ||
               a == 8'h28 || a == 8'h2C || a == 8'h30;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return ID_W;
            8'h10: return CFG_W;
            8'h20: return pin_in;
            8'h24: return m_dout;
            8'h28: return m_dir;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            8'h24: m_dout = d;
            8'h2C: m_dout = m_dout & ~d;
            8'h30: m_dout = m_dout | d;
            8'h28: m_dir  = d;
            default: ;
        endcase
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_pins(input string req);
        check({req, " pin_out"}, pin_out, m_dout);
        check({req, " pin_oe"}, pin_oe, m_dir);
    endtask

    initial begin
        logic [31:0] rd;
        logic [31:0] hold;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        rst = 1'b0;

        // R7: fixed words
        do_read(8'h00, rd); check("R7 id", rd, ID_W);
        do_read(8'h10, rd); check("R7 cfg", rd, CFG_W);

        // R2: full data-out write and readback
        do_write(8'h24, 32'hA5A5_F00F); check_pins("R2");
        do_read(8'h24, rd); check("R2 readback", rd, 32'hA5A5_F00F);

        // R3 / R4: aliases, including all-ones and all-zeros masks
        do_write(8'h2C, 32'h0000_000F); check_pins("R3");
        do_write(8'h30, 32'h0F00_0000); check_pins("R4");
        do_write(8'h30, 32'h0); check_pins("R4 zero mask");
        do_write(8'h2C, 32'hFFFF_FFFF); check_pins("R3 all");
        do_write(8'h30, 32'hFFFF_FFFF); check_pins("R4 all");

        // R5: direction
        do_write(8'h28, 32'h8000_0001); check_pins("R5");
        do_read(8'h28, rd); check("R5 readback", rd, 32'h8000_0001);

        // R8: writes to read-only and unmapped offsets
        do_write(8'h00, 32'h1234_5678); check_pins("R8 ro id");
        do_write(8'h20, 32'h0);          check_pins("R8 ro din");
        do_write(8'h26, 32'h0);          check_pins("R8 unaligned");
        do_read(8'h30, rd); check("R8 alias read", rd, 32'h0);
        do_read(8'hFC, rd); check("R8 unmapped read", rd, 32'h0);

        // R6: data-in after two edges
        pin_in = 32'hDEAD_BEEF;
        repeat (2) @(negedge clk);
        do_read(8'h20, rd); check("R6 din", rd, 32'hDEAD_BEEF);

        // R9: hold while no read
        hold = bus_rdata;
        pin_in = 32'h1111_2222;
        do_write(8'h24, 32'h5555_AAAA);
        repeat (3) @(negedge clk);
        check("R9 hold", bus_rdata, hold);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] a;
            logic [31:0] d;
            op = $urandom_range(0, 9);
            d  = $urandom();
            case (op)
                0: begin do_write(8'h24, d); check_pins("R2 rnd"); end
                1: begin do_write(8'h2C, d); check_pins("R3 rnd"); end
                2: begin do_write(8'h30, d); check_pins("R4 rnd"); end
                3: begin do_write(8'h28, d); check_pins("R5 rnd"); end
                4: begin
                    pin_in = d;
                    repeat (2) @(negedge clk);
                    do_read(8'h20, rd); check("R6 rnd", rd, d);
                end
                5: begin
                    a = 8'($urandom());
                    if (!is_mapped(a)) begin
                        do_write(a, d); check_pins("R8 rnd write");
                        do_read(a, rd); check("R8 rnd read", rd, 32'h0);
                    end
                end
                default: begin
                    case ($urandom_range(0, 4))
                        0: a = 8'h00;
                        1: a = 8'h10;
                        2: a = 8'h24;
                        3: a = 8'h28;
                        default: a = 8'h2C;
                    endcase
                    do_read(a, rd);
                    check(a == 8'h00 || a == 8'h10 ? "R7 rnd" : "R9 rnd", rd, exp_read(a));
                end
            endcase
        end

        // R1: reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_dout = '0; m_dir = '0;
        check_pins("R1 rerst");
        check("R1 rerst rdata", bus_rdata, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule